// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Stall Unit

This block resolves read-after-write data hazards in a five-stage in-order pipeline. It compares the source register numbers of the instruction in the execute stage with the destinations of the two older instructions still in the memory and write-back stages. From that comparison it steers each ALU operand to one of three values: the register-file read, the result in the memory stage, or the result in the write-back stage. When two older producers write the same register, the younger one is chosen.

A second part handles the one case forwarding cannot cover. That case is a load in the execute stage whose destination is needed by the instruction currently being decoded. For that cycle the unit holds the program counter and the fetch/decode register. It also asks for the control bits entering the decode/execute register to be cleared, which puts a bubble into the pipeline. A cycle later the load sits in the memory stage and no longer matches. Its data then reaches the dependent instruction through write-back forwarding. The select codes, the operand values and the hold signals are all combinational. The clock and reset only sample the embedded property checks.

Top module: `hz_forward_stall_unit`

## Requirements
- R1: Operand A select is 2'b10, and ALU input A carries the memory-stage result, whenever the memory stage writes a register, its destination is nonzero and that destination equals the execute-stage rs.
- R2: Operand B follows the R1 rule, comparing against the execute-stage rt and driving ALU input B.
- R3: An operand select is 2'b01, and its ALU input carries the write-back result, when the write-back stage writes a nonzero destination equal to that operand's source and the R1/R2 condition for that operand does not hold.
- R4: When both stages match the same operand, the memory-stage result (2'b10) is chosen, so three consecutive writes to one register deliver the middle result.
- R5: A destination of register 0 is never forwarded; the operand stays on the register-file value.
- R6: With no matching producer the select is 2'b00 and the ALU input equals the register-file read; the code 2'b11 never appears.
- R7: Selects and ALU inputs change in the same cycle as the register numbers and flags, with no register in the path.
- R8: When the execute stage is a memory read whose rt equals the decode-stage rs or rt, pc_hold, ifid_hold and idex_bubble are all 1; at all other times all three are 0.
- R9: A matching rt without the memory-read flag raises no stall.
- R10: The stall comparison does not exclude register 0: a load to register 0 followed by a reader of register 0 still stalls.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Sampling clock for embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables checks |
| ifid_rs | input | 5 | rs of the instruction being decoded |
| ifid_rt | input | 5 | rt of the instruction being decoded |
| idex_rs | input | 5 | rs of the instruction in execute |
| idex_rt | input | 5 | rt of the instruction in execute |
| idex_mem_rd | input | 1 | Execute-stage instruction reads memory |
| exmem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| exmem_rd | input | 5 | Memory-stage destination register |
| memwb_reg_wr | input | 1 | Write-back-stage instruction writes a register |
| memwb_rd | input | 5 | Write-back-stage destination register |
| rf_rs_data | input | 32 | Register-file value for operand A |
| rf_rt_data | input | 32 | Register-file value for operand B |
| exmem_result | input | 32 | Result held in the memory stage |
| memwb_result | input | 32 | Value being written back |
| fwd_a_sel | output | 2 | Operand A select code |
| fwd_b_sel | output | 2 | Operand B select code |
| alu_in_a | output | 32 | Selected ALU operand A |
| alu_in_b | output | 32 | Selected ALU operand B |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Clear control bits entering decode/execute |

## Verification
On every cycle the assertions check several properties. The memory-stage match drives operand A to the memory result, and write-back forwarding is never chosen while the memory stage also matches. No select points at register 0, and the code 2'b11 never appears. The three hold outputs always move together and only ever rise with a memory read in execute. The scenarios are needed for the rest, because only they fix which value was expected. These cover add chains, the triple write to one register, destination zero, load-use and load-to-zero stalls, and a non-load whose rt matches.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_W  = 5;
    localparam int SEL_W  = 2;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic     wr;
        reg_idx_t rd;
    } producer_t;

    function automatic logic producer_hits(producer_t p, reg_idx_t src);
        return p.wr && (p.rd != '0) && (p.rd == src);
    endfunction
endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_idx_t  src,
    input  producer_t mem_stage,
    input  producer_t wb_stage,
    output fwd_sel_e  sel
);
    logic mem_hit;
    logic wb_hit;

    assign mem_hit = producer_hits(mem_stage, src);
    assign wb_hit  = producer_hits(wb_stage, src);

    always_comb begin
        if (mem_hit)
            sel = SEL_MEM;
        else if (wb_hit)
            sel = SEL_WB;
        else
            sel = SEL_RF;
    end

    // R3/R4: write-back path only when the younger producer misses
    p_wb_only_on_mem_miss_r3: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_WB) |-> !(mem_stage.wr && mem_stage.rd == src && src != '0));

    // R5: never forward from register 0
    p_no_zero_forward_r5: assert property (@(posedge clk) disable iff (rst)
        (sel != SEL_RF) |-> (src != '0));
endmodule

// File: rtl/hz_operand_mux.sv
module hz_operand_mux
    import hz_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  fwd_sel_e        sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] mem_val,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] operand
);
    always_comb begin
        unique case (sel)
            SEL_MEM: operand = mem_val;
            SEL_WB:  operand = wb_val;
            default: operand = rf_val;
        endcase
    end

    // R6: the unused code never reaches the multiplexer
    p_sel_legal_r6: assert property (@(posedge clk) disable iff (rst)
        sel != fwd_sel_e'(2'b11));
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ex_mem_read,
    input  reg_idx_t ex_rt,
    input  reg_idx_t dec_rs,
    input  reg_idx_t dec_rt,
    output logic     stall
);
    assign stall = ex_mem_read && ((ex_rt == dec_rs) || (ex_rt == dec_rt));

    // R9: a stall always has a load in execute behind it
    p_stall_needs_load_r9: assert property (@(posedge clk) disable iff (rst)
        stall |-> ex_mem_read);
endmodule

// File: rtl/hz_forward_stall_unit.sv
module hz_forward_stall_unit
    import hz_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       ifid_rs,
    input  logic [4:0]       ifid_rt,
    input  logic [4:0]       idex_rs,
    input  logic [4:0]       idex_rt,
    input  logic             idex_mem_rd,
    input  logic             exmem_reg_wr,
    input  logic [4:0]       exmem_rd,
    input  logic             memwb_reg_wr,
    input  logic [4:0]       memwb_rd,
    input  logic [XLEN-1:0]  rf_rs_data,
    input  logic [XLEN-1:0]  rf_rt_data,
    input  logic [XLEN-1:0]  exmem_result,
    input  logic [XLEN-1:0]  memwb_result,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic [XLEN-1:0]  alu_in_a,
    output logic [XLEN-1:0]  alu_in_b,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);
    localparam int N_OPND = 2;

    producer_t        mem_prod;
    producer_t        wb_prod;
    reg_idx_t         opnd_src [N_OPND];
    logic [XLEN-1:0]  opnd_rf  [N_OPND];
    fwd_sel_e         opnd_sel [N_OPND];
    logic [XLEN-1:0]  opnd_out [N_OPND];
    logic             lu_stall;

    assign mem_prod = '{wr: exmem_reg_wr, rd: exmem_rd};
    assign wb_prod  = '{wr: memwb_reg_wr, rd: memwb_rd};

    assign opnd_src[0] = idex_rs;
    assign opnd_src[1] = idex_rt;
    assign opnd_rf[0]  = rf_rs_data;
    assign opnd_rf[1]  = rf_rt_data;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hz_fwd_select u_sel (
            .clk       (clk),
            .rst       (rst),
            .src       (opnd_src[g]),
            .mem_stage (mem_prod),
            .wb_stage  (wb_prod),
            .sel       (opnd_sel[g])
        );

        hz_operand_mux #(.XLEN(XLEN)) u_mux (
            .clk     (clk),
            .rst     (rst),
            .sel     (opnd_sel[g]),
            .rf_val  (opnd_rf[g]),
            .mem_val (exmem_result),
            .wb_val  (memwb_result),
            .operand (opnd_out[g])
        );
    end

    hz_load_use u_lu (
        .clk         (clk),
        .rst         (rst),
        .ex_mem_read (idex_mem_rd),
        .ex_rt       (idex_rt),
        .dec_rs      (ifid_rs),
        .dec_rt      (ifid_rt),
        .stall       (lu_stall)
    );

    assign fwd_a_sel   = opnd_sel[0];
    assign fwd_b_sel   = opnd_sel[1];
    assign alu_in_a    = opnd_out[0];
    assign alu_in_b    = opnd_out[1];
    assign pc_hold     = lu_stall;
    assign ifid_hold   = lu_stall;
    assign idex_bubble = lu_stall;

    // R1: memory-stage producer reaches operand A
    p_mem_to_a_r1: assert property (@(posedge clk) disable iff (rst)
        (exmem_reg_wr && exmem_rd != 5'd0 && exmem_rd == idex_rs) |-> (alu_in_a == exmem_result));

    // R2: memory-stage producer reaches operand B
    p_mem_to_b_r2: assert property (@(posedge clk) disable iff (rst)
        (exmem_reg_wr && exmem_rd != 5'd0 && exmem_rd == idex_rt) |-> (alu_in_b == exmem_result));

    // R8: the three hold outputs move as one
    p_hold_together_r8: assert property (@(posedge clk) disable iff (rst)
        (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));
endmodule

// File: tb/hz_forward_stall_unit_bench.sv
module hz_forward_stall_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0] ifid_rs = '0, ifid_rt = '0, idex_rs = '0, idex_rt = '0;
    logic idex_mem_rd = 1'b0, exmem_reg_wr = 1'b0, memwb_reg_wr = 1'b0;
    logic [4:0] exmem_rd = '0, memwb_rd = '0;
    logic [XLEN-1:0] rf_rs_data = 32'h1111_0000, rf_rt_data = 32'h2222_0000;
    logic [XLEN-1:0] exmem_result = 32'hAAAA_0001, memwb_result = 32'hBBBB_0002;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic [XLEN-1:0] alu_in_a, alu_in_b;
    logic pc_hold, ifid_hold, idex_bubble;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hz_forward_stall_unit #(.XLEN(XLEN)) u_hz_forward_stall_unit (
        .clk(clk), .rst(rst),
        .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
        .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_mem_rd(idex_mem_rd),
        .exmem_reg_wr(exmem_reg_wr), .exmem_rd(exmem_rd),
        .memwb_reg_wr(memwb_reg_wr), .memwb_rd(memwb_rd),
        .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
        .exmem_result(exmem_result), .memwb_result(memwb_result),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .alu_in_a(alu_in_a), .alu_in_b(alu_in_b),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive after the falling edge, sample mid-low phase
    task automatic apply(logic [4:0] es, logic [4:0] et, logic mw, logic [4:0] md,
                         logic ww, logic [4:0] wd);
        @(negedge clk);
        idex_rs = es; idex_rt = et;
        exmem_reg_wr = mw; exmem_rd = md;
        memwb_reg_wr = ww; memwb_rd = wd;
        #1;
    endtask

    task automatic t_reset_idle();
        apply(5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
        chk("R6 a sel", 64'(fwd_a_sel), 64'(2'b00));
        chk("R6 b sel", 64'(fwd_b_sel), 64'(2'b00));
        chk("R6 a val", 64'(alu_in_a), 64'(rf_rs_data));
        chk("R8 idle hold", 64'({pc_hold, ifid_hold, idex_bubble}), 64'(3'b000));
    endtask

    task automatic t_add_chain();
        // add r3 in MEM feeding A; add r4 in WB feeding B
        apply(5'd3, 5'd4, 1'b1, 5'd3, 1'b1, 5'd4);
        chk("R1 a sel", 64'(fwd_a_sel), 64'(2'b10));
        chk("R1 a val", 64'(alu_in_a), 64'(exmem_result));
        chk("R3 b sel", 64'(fwd_b_sel), 64'(2'b01));
        chk("R3 b val", 64'(alu_in_b), 64'(memwb_result));
        apply(5'd7, 5'd3, 1'b1, 5'd3, 1'b0, 5'd7);
        chk("R2 b sel", 64'(fwd_b_sel), 64'(2'b10));
        chk("R2 b val", 64'(alu_in_b), 64'(exmem_result));
        chk("R3 no wr a", 64'(fwd_a_sel), 64'(2'b00));
    endtask

    task automatic t_triple_same_dest();
        apply(5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1);
        chk("R4 a sel", 64'(fwd_a_sel), 64'(2'b10));
        chk("R4 b sel", 64'(fwd_b_sel), 64'(2'b10));
        chk("R4 a val", 64'(alu_in_a), 64'(exmem_result));
        // MEM writes other reg: WB still matches
        apply(5'd1, 5'd2, 1'b1, 5'd9, 1'b1, 5'd1);
        chk("R3 a after mem miss", 64'(fwd_a_sel), 64'(2'b01));
    endtask

    task automatic t_zero_dest();
        apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        chk("R5 a sel", 64'(fwd_a_sel), 64'(2'b00));
        chk("R5 b val", 64'(alu_in_b), 64'(rf_rt_data));
    endtask

    task automatic t_comb_response();
        apply(5'd5, 5'd6, 1'b0, 5'd5, 1'b0, 5'd6);
        chk("R7 before", 64'(fwd_a_sel), 64'(2'b00));
        exmem_reg_wr = 1'b1;
        #1;
        chk("R7 same cycle", 64'(fwd_a_sel), 64'(2'b10));
        exmem_result = 32'hCAFE_0042;
        #1;
        chk("R7 data follows", 64'(alu_in_a), 64'(32'hCAFE_0042));
    endtask

    task automatic t_load_use();
        @(negedge clk);
        idex_mem_rd = 1'b1; idex_rt = 5'd8; ifid_rs = 5'd8; ifid_rt = 5'd2;
        #1;
        chk("R8 rs hazard", 64'({pc_hold, ifid_hold, idex_bubble}), 64'(3'b111));
        ifid_rs = 5'd3; ifid_rt = 5'd8;
        #1;
        chk("R8 rt hazard", 64'({pc_hold, ifid_hold, idex_bubble}), 64'(3'b111));
        ifid_rt = 5'd4;
        #1;
        chk("R8 no match", 64'({pc_hold, ifid_hold, idex_bubble}), 64'(3'b000));
        // next cycle: bubble in EX, load now in MEM/WB supplies value
        @(negedge clk);
        idex_mem_rd = 1'b0; ifid_rs = 5'd0; ifid_rt = 5'd0;
        apply(5'd8, 5'd2, 1'b0, 5'd0, 1'b1, 5'd8);
        chk("R8 after stall", 64'(pc_hold), 64'(1'b0));
        chk("R3 load value", 64'(alu_in_a), 64'(memwb_result));
    endtask

    task automatic t_nonload_match();
        @(negedge clk);
        idex_mem_rd = 1'b0; idex_rt = 5'd10; ifid_rs = 5'd10; ifid_rt = 5'd10;
        #1;
        chk("R9 no stall", 64'({pc_hold, ifid_hold, idex_bubble}), 64'(3'b000));
    endtask

    task automatic t_load_zero();
        @(negedge clk);
        idex_mem_rd = 1'b1; idex_rt = 5'd0; ifid_rs = 5'd0; ifid_rt = 5'd12;
        #1;
        chk("R10 zero stall", 64'({pc_hold, ifid_hold, idex_bubble}), 64'(3'b111));
        @(negedge clk);
        idex_mem_rd = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_idle();
        t_add_chain();
        t_triple_same_dest();
        t_zero_dest();
        t_comb_response();
        t_load_use();
        t_nonload_match();
        t_load_zero();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule